// File: doc/BRIEF.md
# Wait-State External Bus Sequencer

This block sits between a processor core and an external 8-bit bus. It turns each internal memory or I/O access into an external bus cycle with three phases. In the address phase the chip select goes low and the address is held on the bus. In the strobe phase the read or write strobe goes low, together with a memory-space or I/O-space qualifier. The hold phase then keeps every pin where it is, and the read byte is captured on the last clock edge of this phase. A slow device can stretch the cycle by pulling an active-low wait line. That line passes through a two-flop synchronizer, and it adds wait clocks only if its synchronized value is low on the final clock of the strobe phase.

A three-bit setting selects how many system clocks each of the three timed phases lasts, from one to eight. The core offers a request with a valid flag and sees it taken by a ready flag. Completion comes back as a one-clock done pulse. The captured read byte is valid in the same clock as that pulse. A request that is pending when the hold phase ends starts its address phase on the very next clock, so back-to-back cycles leave no idle clock between them. The data pins are split into an output byte, an output enable and an input byte, so the pad ring can build the tri-state buffer.

Top module: `xbus_seq`

## Requirements
- R1: After reset the chip select and all four strobes are high, the output enable is low, ready is high and done is low. The phase-length setting resets to code 0, which means one clock per phase.
- R2: The phase-length code c (3 bits) makes each of the address, strobe and hold phases last c+1 clocks. During the address phase the chip select is low, the request's address is on the bus and all four strobes stay high.
- R3: In the strobe phase, read strobe low marks a read and write strobe low marks a write. A memory request (I/O flag 0) drives the memory qualifier low, and an I/O request (I/O flag 1) drives the I/O qualifier low. The two strobes are never low together, and neither are the two qualifiers.
- R4: Without wait states, the strobes stay low for exactly 2(c+1) clocks: the strobe phase plus the hold phase.
- R5: If the synchronized wait line is low on the last clock of the strobe phase, wait clocks follow until it is seen high. Address, strobes and qualifiers do not change during wait clocks or the hold phase.
- R6: A wait pulse that reaches the synchronizer output only after the last strobe-phase clock adds no wait clocks.
- R7: The read byte is captured on the clock edge that ends the hold phase. It is presented on the read-data output during the one-clock done pulse that follows.
- R8: The output enable is high for every clock in which the chip select of a write cycle is low, and the write byte is on the data output during that time. The enable is low during read cycles and when the bus is idle.
- R9: Ready is high only when the sequencer is idle or in the last clock of the hold phase. A request pending at that last clock starts its address phase on the next clock, and the chip select does not go high in between.
- R10: When no request follows, the chip select and all strobes are high again in the clock after the hold phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Write strobe for the phase-length setting |
| cfg_code | input | 3 | Clocks per phase minus one |
| req_valid | input | 1 | Access request pending |
| req_ready | output | 1 | Request taken at this clock edge |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 8 | Captured read byte |
| bus_addr | output | 16 | External address |
| bus_dout | output | 8 | External data out |
| bus_doe | output | 1 | Data output enable |
| bus_din | input | 8 | External data in |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_mreq_n | output | 1 | Memory qualifier, active low |
| bus_iorq_n | output | 1 | I/O qualifier, active low |
| bus_wait_n | input | 1 | Asynchronous wait, active low |

## Verification
The stimulus mixes reads and writes in both address spaces at phase lengths of one, two, four and eight clocks. Each length produces its own address-phase and strobe-phase count, so an off-by-one in the phase timer shows up directly. Three wait patterns are applied. A long wait asserted during the address phase must lengthen the strobes by an exact number of clocks, which is a check on the synchronizer depth and the decision point. A short pulse raised inside a one-clock strobe phase must change nothing, which is a check that the decision uses the synchronized value. A quiet line gives the baseline. A held write followed by a read checks that back-to-back cycles run without a gap and that the request is not taken early.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_TW   = 3'd3,
    PH_T3   = 3'd4
  } phase_e;

  // chip select is low in every non-idle phase
  function automatic logic phase_in_cycle(phase_e p);
    return p != PH_IDLE;
  endfunction

  // strobes are low from the strobe phase through the hold phase
  function automatic logic phase_strobe(phase_e p);
    return (p == PH_T2) || (p == PH_TW) || (p == PH_T3);
  endfunction

  // clocks spent in one timed phase for a given setting code
  function automatic int unsigned clocks_per_phase(int unsigned code);
    return code + 1;
  endfunction

endpackage

// File: rtl/xbus_wait_sync.sv
module xbus_wait_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_n,
  output logic sync_n
);
  logic [STAGES-1:0] chain_q;

  // reset to "not waiting" so a freshly reset bus never stalls
  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b1;
          else        chain_q[0] <= async_n;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b1;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/xbus_phase_timer.sv
module xbus_phase_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/xbus_phase_ctrl.sv
module xbus_phase_ctrl
  import xbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_code,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_write,
  input  logic          req_io,
  input  logic          wait_ok,
  input  logic [DW-1:0] bus_din,
  output phase_e        phase,
  output logic          phase_end,
  output logic          t3_last,
  output logic [CW-1:0] cfg_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic          write_q,
  output logic          io_q,
  output logic          req_ready,
  output logic          done,
  output logic [DW-1:0] rdata
);
  phase_e ph_q, ph_d;
  logic   load;
  logic   accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_code;
  end

  xbus_phase_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (cfg_q),
    .expired  (phase_end)
  );

  always_comb begin
    ph_d = ph_q;
    load = 1'b0;
    unique case (ph_q)
      PH_IDLE: if (req_valid) begin ph_d = PH_T1; load = 1'b1; end
      PH_T1:   if (phase_end) begin ph_d = PH_T2; load = 1'b1; end
      PH_T2:   if (phase_end) begin
                 ph_d = wait_ok ? PH_T3 : PH_TW;
                 load = 1'b1;
               end
      PH_TW:   if (wait_ok)   begin ph_d = PH_T3; load = 1'b1; end
      PH_T3:   if (phase_end) begin
                 ph_d = req_valid ? PH_T1 : PH_IDLE;
                 load = 1'b1;
               end
      default: ph_d = PH_IDLE;
    endcase
  end

  assign t3_last   = (ph_q == PH_T3) && phase_end;
  assign req_ready = (ph_q == PH_IDLE) || t3_last;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
      io_q    <= 1'b0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      write_q <= req_write;
      io_q    <= req_io;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done  <= 1'b0;
      rdata <= '0;
    end else begin
      done <= t3_last;
      if (t3_last && !write_q) rdata <= bus_din;
    end
  end

  assign phase = ph_q;
endmodule

// File: rtl/xbus_pin_map.sv
module xbus_pin_map
  import xbus_pkg::*;
(
  input  phase_e phase,
  input  logic   write_q,
  input  logic   io_q,
  output logic   cs_n,
  output logic   rd_n,
  output logic   wr_n,
  output logic   mreq_n,
  output logic   iorq_n,
  output logic   doe
);
  logic in_cyc, strb;

  always_comb begin
    in_cyc = phase_in_cycle(phase);
    strb   = phase_strobe(phase);
    cs_n   = !in_cyc;
    rd_n   = !(strb && !write_q);
    wr_n   = !(strb && write_q);
    mreq_n = !(strb && !io_q);
    iorq_n = !(strb && io_q);
    doe    = in_cyc && write_q;
  end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int CFG_W     = 3,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_code,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_write,
  input  logic              req_io,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  input  logic [DATA_W-1:0] bus_din,
  output logic              bus_cs_n,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic              bus_mreq_n,
  output logic              bus_iorq_n,
  input  logic              bus_wait_n
);
  // named internal events, also observed by the bound checker
  phase_e             phase;
  logic               phase_end;
  logic               t3_last;
  logic               wait_ok;
  logic [CFG_W-1:0]   cfg_q;
  logic               write_q, io_q;

  xbus_wait_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_n (bus_wait_n),
    .sync_n  (wait_ok)
  );

  xbus_phase_ctrl #(.AW(ADDR_W), .DW(DATA_W), .CW(CFG_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_code  (cfg_code),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_write (req_write),
    .req_io    (req_io),
    .wait_ok   (wait_ok),
    .bus_din   (bus_din),
    .phase     (phase),
    .phase_end (phase_end),
    .t3_last   (t3_last),
    .cfg_q     (cfg_q),
    .addr_q    (bus_addr),
    .wdata_q   (bus_dout),
    .write_q   (write_q),
    .io_q      (io_q),
    .req_ready (req_ready),
    .done      (rsp_done),
    .rdata     (rsp_rdata)
  );

  xbus_pin_map u_pins (
    .phase   (phase),
    .write_q (write_q),
    .io_q    (io_q),
    .cs_n    (bus_cs_n),
    .rd_n    (bus_rd_n),
    .wr_n    (bus_wr_n),
    .mreq_n  (bus_mreq_n),
    .iorq_n  (bus_iorq_n),
    .doe     (bus_doe)
  );
endmodule

// File: rtl/xbus_seq_chk.sv
module xbus_seq_chk
  import xbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          rd_n,
  input logic          wr_n,
  input logic          mreq_n,
  input logic          iorq_n,
  input logic          doe,
  input logic          done,
  input logic [AW-1:0] addr,
  input phase_e        phase,
  input logic          phase_end,
  input logic          t3_last,
  input logic          wait_ok,
  input logic [CW-1:0] cfg_q
);
  logic       strb;
  logic [7:0] t1_cnt;

  assign strb = !rd_n || !wr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              t1_cnt <= '0;
    else if (phase == PH_T1) t1_cnt <= t1_cnt + 8'd1;
    else                     t1_cnt <= '0;
  end

  a_r3_dir_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  a_r3_space_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mreq_n && !iorq_n));
  a_r3_strobe_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    strb |-> (!cs_n && (!mreq_n || !iorq_n)));
  a_r2_t1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_T1) |-> (!cs_n && rd_n && wr_n && mreq_n && iorq_n));
  a_r2_t1_length: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_T1 && phase_end) |->
      ((32'(t1_cnt) + 32'd1) == clocks_per_phase(32'(cfg_q))));
  a_r5_pins_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (strb && $past(strb)) |->
      ($stable(addr) && $stable(rd_n) && $stable(wr_n) && $stable(mreq_n) && $stable(iorq_n)));
  a_r5_wait_enter: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_T2 && phase_end && !wait_ok) |=> (phase == PH_TW));
  a_r5_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_TW && !wait_ok) |=> (phase == PH_TW));
  a_r6_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_T2 && phase_end && wait_ok) |=> (phase == PH_T3));
  a_r7_done_follows_t3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(t3_last));
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_oe_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    doe |-> (!cs_n && rd_n));
endmodule

bind xbus_seq xbus_seq_chk #(.AW(ADDR_W), .CW(CFG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (bus_cs_n),
  .rd_n      (bus_rd_n),
  .wr_n      (bus_wr_n),
  .mreq_n    (bus_mreq_n),
  .iorq_n    (bus_iorq_n),
  .doe       (bus_doe),
  .done      (rsp_done),
  .addr      (bus_addr),
  .phase     (phase),
  .phase_end (phase_end),
  .t3_last   (t3_last),
  .wait_ok   (wait_ok),
  .cfg_q     (cfg_q)
);

// File: tb/xbus_seq_tb.sv
`timescale 1ns/1ps
module xbus_seq_tb;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [CW-1:0] cfg_code = '0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_write = 1'b0;
  logic          req_io = 1'b0;
  logic          rsp_done;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_dout;
  logic          bus_doe;
  logic [DW-1:0] bus_din;
  logic          bus_cs_n, bus_rd_n, bus_wr_n, bus_mreq_n, bus_iorq_n;
  logic          bus_wait_n = 1'b1;

  always #4 clk = ~clk;

  xbus_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_code(cfg_code),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_write(req_write), .req_io(req_io),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din),
    .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_mreq_n(bus_mreq_n), .bus_iorq_n(bus_iorq_n), .bus_wait_n(bus_wait_n)
  );

  // simple external device: read byte derived from the address
  function automatic logic [DW-1:0] dev_byte(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction
  assign bus_din = !bus_rd_n ? dev_byte(bus_addr) : '0;

  typedef struct {
    logic          wr;
    logic          io;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    int            s_exp;
    int            t1_exp;
    string         s_tag;
  } exp_t;

  exp_t sbq[$];
  int   checks = 0, errors = 0;
  int   cur_n = 1;
  int   n_done = 0;
  int   b2b_target = 0;
  bit   b2b_on = 1'b0;
  int   b2b_gap = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: per-cycle bus record, popped against the scoreboard on done
  int   m_s, m_t1, m_oe;
  bit   m_rd, m_wr, m_mreq, m_iorq;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_wdata;

  initial begin
    m_s = 0; m_t1 = 0; m_oe = 0;
    m_rd = 0; m_wr = 0; m_mreq = 0; m_iorq = 0;
    m_addr = '0; m_wdata = '0;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_done) begin
        n_done++;
        if (sbq.size() == 0) begin
          chk(1'b0, "R7", "done without request", 1, 0);
        end else begin
          exp_t e;
          e = sbq.pop_front();
          chk(m_wr == e.wr && m_rd == !e.wr, "R3", "direction strobe",
              int'({m_wr, m_rd}), int'({e.wr, !e.wr}));
          chk(m_iorq == e.io && m_mreq == !e.io, "R3", "space qualifier",
              int'({m_iorq, m_mreq}), int'({e.io, !e.io}));
          chk(m_addr == e.addr, "R2", "address", int'(m_addr), int'(e.addr));
          chk(m_t1 == e.t1_exp, "R2", "address phase clocks", m_t1, e.t1_exp);
          chk(m_s == e.s_exp, e.s_tag, "strobe clocks", m_s, e.s_exp);
          if (e.wr) begin
            chk(m_wdata == e.data, "R8", "write byte", int'(m_wdata), int'(e.data));
            chk(m_oe == m_t1 + m_s, "R8", "enable clocks", m_oe, m_t1 + m_s);
          end else begin
            chk(rsp_rdata == e.data, "R7", "read byte", int'(rsp_rdata), int'(e.data));
            chk(m_oe == 0, "R8", "enable in read", m_oe, 0);
          end
        end
        m_s = 0; m_t1 = 0; m_oe = 0;
        m_rd = 0; m_wr = 0; m_mreq = 0; m_iorq = 0;
      end
      if (!bus_cs_n) begin
        if (bus_doe) m_oe++;
        if (bus_rd_n && bus_wr_n) m_t1++;
        else begin
          m_s++;
          m_addr = bus_addr;
          if (!bus_rd_n)   m_rd = 1'b1;
          if (!bus_wr_n)   begin m_wr = 1'b1; m_wdata = bus_dout; end
          if (!bus_mreq_n) m_mreq = 1'b1;
          if (!bus_iorq_n) m_iorq = 1'b1;
        end
      end
      if (b2b_on && n_done < b2b_target && bus_cs_n) b2b_gap++;
    end
  end

  // driver: pushes the expected item, then offers the request
  task automatic send(input bit wr, input bit io, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input int s_exp,
                      input string tag, input bit hold);
    exp_t e;
    e.wr = wr; e.io = io; e.addr = a;
    e.data = wr ? d : dev_byte(a);
    e.s_exp = s_exp; e.t1_exp = cur_n; e.s_tag = tag;
    sbq.push_back(e);
    req_valid = 1'b1; req_write = wr; req_io = io;
    req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    if (!hold) req_valid = 1'b0;
  endtask

  task automatic set_cfg(input int c);
    cfg_we = 1'b1; cfg_code = CW'(c);
    @(negedge clk);
    cfg_we = 1'b0;
    cur_n = c + 1;
  endtask

  task automatic drain();
    while (sbq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_early(input int k);
    while (bus_cs_n) @(negedge clk);
    bus_wait_n = 1'b0;
    repeat (k) @(negedge clk);
    bus_wait_n = 1'b1;
  endtask

  task automatic wait_late();
    while (bus_rd_n) @(negedge clk);
    bus_wait_n = 1'b0;
    @(negedge clk);
    bus_wait_n = 1'b1;
  endtask

  task automatic idle_pins(input string tag);
    chk(bus_cs_n && bus_rd_n && bus_wr_n && bus_mreq_n && bus_iorq_n, tag,
        "pins high when idle",
        int'({bus_cs_n, bus_rd_n, bus_wr_n, bus_mreq_n, bus_iorq_n}), 31);
    chk(!bus_doe, tag, "enable low when idle", int'(bus_doe), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    idle_pins("R1");
    chk(req_ready, "R1", "ready after reset", int'(req_ready), 1);
    chk(!rsp_done, "R1", "done after reset", int'(rsp_done), 0);

    // R1 default of one clock per phase, R4 baseline, R7 read capture
    send(1'b0, 1'b0, 16'h1234, 8'h00, 2, "R4", 1'b0);
    send(1'b1, 1'b0, 16'h2345, 8'h3C, 2, "R4", 1'b0);
    drain();
    idle_pins("R10");

    // R2 longer phases, I/O space
    set_cfg(3);
    send(1'b0, 1'b1, 16'h00F1, 8'h00, 8, "R4", 1'b0);
    chk(!req_ready, "R9", "ready low inside cycle", int'(req_ready), 0);
    send(1'b1, 1'b1, 16'h00F2, 8'hC3, 8, "R4", 1'b0);
    drain();
    set_cfg(7);
    send(1'b1, 1'b0, 16'hBEEF, 8'h5A, 16, "R4", 1'b0);
    drain();
    idle_pins("R10");

    // R5 wait asserted early: with two clocks per phase, release after 6 clocks
    set_cfg(1);
    fork
      send(1'b0, 1'b0, 16'h4321, 8'h00, 9, "R5", 1'b0);
      wait_early(6);
    join
    drain();
    fork
      send(1'b1, 1'b1, 16'h0077, 8'h99, 9, "R5", 1'b0);
      wait_early(6);
    join
    drain();

    // R6 pulse arriving too late for a one-clock strobe phase
    set_cfg(0);
    fork
      send(1'b0, 1'b0, 16'h5555, 8'h00, 2, "R6", 1'b0);
      wait_late();
    join
    drain();
    repeat (3) @(negedge clk);

    // R9 back-to-back: held write then read with no idle clock
    b2b_target = n_done + 2;
    send(1'b1, 1'b0, 16'h0A0A, 8'hE7, 2, "R4", 1'b1);
    b2b_gap = 0;
    b2b_on = 1'b1;
    send(1'b0, 1'b0, 16'h0B0B, 8'h00, 2, "R4", 1'b0);
    drain();
    b2b_on = 1'b0;
    chk(b2b_gap == 0, "R9", "idle clocks between back-to-back cycles", b2b_gap, 0);
    idle_pins("R10");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule